// File: doc/BRIEF.md
# Expansion Bus Device Select Decoder

This block sits between a 6502-style expansion bus and a peripheral that bundles up to four functions behind one bus connection. Several such peripherals can share the bus. They all use one shared byte address for two jobs. A write to it selects or deselects devices. A read of it returns each device's interrupt identification bits. The block keeps a select latch. It opens its register, RAM and ROM windows only while its own select bit is set. When the shared byte is read, it drives only the data bits this device owns. Every other bit stays high-impedance, so two peripherals never fight over the byte.

The block runs on a fast clock that is locked to the bus clock. The bus phase arrives as a sampled level. A three-state machine follows each bus cycle:
- `ST_IDLE` waits for the phase to go high.
- `ST_IDLE -> ST_HIGH` happens when the phase rises. The address and direction are captured on that edge.
- `ST_HIGH` is the access window. Chip-selects and the data output enable are live here, and write data is sampled on every clock.
- `ST_HIGH -> ST_COMMIT` happens when the phase falls.
- `ST_COMMIT` applies a pending write to the internal registers.
- `ST_COMMIT -> ST_IDLE` always follows.

Two registers live inside the block: an indicator (LED) byte and a per-function interrupt enable. The RAM and ROM windows, and the remaining register addresses, are served by outside storage. That storage returns its data on `mem_rdata`.

Top module: `xbus_dev_decoder`

## Requirements
- R1: After reset the select latch is clear, `led` is 0x00, the interrupt enable is 0, all chip-selects are low and `doe` is 0x00.
- R2: A write to 0xD1FF loads bit SEL_BIT (default 0) of the write data into the select latch, whether or not the device is selected. Data bit SEL_BIT = 1 selects the device and 0 deselects it. The other data bits have no effect.
- R3: While deselected, no chip-select is asserted, `doe` is 0x00 for every address except 0xD1FF, and writes to 0xD100 and 0xD101 leave those registers unchanged.
- R4: While selected and in `ST_HIGH`, `cs_reg` is high for 0xD100–0xD1FE, `cs_ram` for 0xD600–0xD7FF and `cs_rom` for 0xD800–0xDFFF (ROM_BYTES = 2048). Every other address, 0xD1FF included, asserts none. At most one chip-select is high at a time.
- R5: A selected write to 0xD100 stores the whole byte in `led`. A selected write to 0xD101 stores data bits [3:0] as the enable for functions 3..0.
- R6: A read of 0xD1FF, selected or not, sets `doe` = 0x0F (bits 0..NFUNC-1). `dout[i]` then equals `irq_req[i]` AND enable bit i, read live. Bits 7..4 are never driven.
- R7: `doe` is non-zero only in `ST_HIGH` of a read cycle whose captured address hits 0xD1FF or an open window. Write cycles never drive the bus.
- R8: A selected read of a window drives `doe` = 0xFF. 0xD100 returns `led`. 0xD101 returns the enable in bits [3:0] with zeros above. All other window addresses return `mem_rdata`.
- R9: Address and direction are taken once, at the phase rise. Changes on `addr` or `rw` while the phase is high do not alter chip-selects, `doe`, or the target of a write.
- R10: Write data is the last value of `din` sampled while the phase was high. It is applied within two clocks after the phase falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock locked to the bus clock |
| rst_n | input | 1 | Active-low bus reset |
| phase | input | 1 | Bus clock phase level, high during the data phase |
| addr | input | 16 | Bus address |
| rw | input | 1 | 1 = read, 0 = write |
| din | input | 8 | Data from the bus on writes |
| mem_rdata | input | 8 | Read data from external RAM/ROM/register storage |
| irq_req | input | 4 | Interrupt request level per function |
| dout | output | 8 | Data to the bus |
| doe | output | 8 | Per-bit data output enable |
| cs_reg | output | 1 | Register window select |
| cs_ram | output | 1 | RAM window select |
| cs_rom | output | 1 | ROM window select |
| led | output | 8 | Indicator register |

## Verification
The hardest condition to reach from the ports is an address or direction change in the middle of the high phase. Real buses do this before the phase falls, and a naive decoder would retarget its selects or its write. The stimulus therefore picks random cycles and, halfway through the high phase, swaps in an unrelated address and flips `rw`. It then checks that the selects, the enables and the committed write still follow the address captured at the rise. Select, deselect and stray bits in the 0xD1FF write are mixed into the random stream. This keeps the window-locked state visited often, including writes to the LED register while locked.

// File: rtl/xbd_pkg.sv
package xbd_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_HIGH,
        ST_COMMIT
    } bus_state_t;

    typedef struct packed {
        logic shared_sel;
        logic reg_win;
        logic ram_win;
        logic rom_win;
        logic led_reg;
        logic ien_reg;
    } hit_t;

endpackage

// File: rtl/xbd_decode.sv
module xbd_decode
    import xbd_pkg::*;
#(
    parameter int REG_BASE  = 16'hD100,
    parameter int REG_BYTES = 256,
    parameter int RAM_BASE  = 16'hD600,
    parameter int RAM_BYTES = 512,
    parameter int ROM_BASE  = 16'hD800,
    parameter int ROM_BYTES = 2048
) (
    input  logic [15:0] addr,
    output hit_t        hit
);
    localparam logic [16:0] REG_LO  = 17'(REG_BASE);
    localparam logic [16:0] REG_HI  = 17'(REG_BASE + REG_BYTES - 2);
    localparam logic [16:0] SEL_A   = 17'(REG_BASE + REG_BYTES - 1);
    localparam logic [16:0] RAM_LO  = 17'(RAM_BASE);
    localparam logic [16:0] RAM_HI  = 17'(RAM_BASE + RAM_BYTES - 1);
    localparam logic [16:0] ROM_LO  = 17'(ROM_BASE);
    localparam logic [16:0] ROM_HI  = 17'(ROM_BASE + ROM_BYTES - 1);
    localparam logic [16:0] LED_A   = 17'(REG_BASE);
    localparam logic [16:0] IEN_A   = 17'(REG_BASE + 1);

    logic [16:0] a;

    always_comb begin
        a              = {1'b0, addr};
        hit.shared_sel = (a == SEL_A);
        hit.reg_win    = (a >= REG_LO) && (a <= REG_HI);
        hit.ram_win    = (a >= RAM_LO) && (a <= RAM_HI);
        hit.rom_win    = (a >= ROM_LO) && (a <= ROM_HI);
        hit.led_reg    = (a == LED_A);
        hit.ien_reg    = (a == IEN_A);
    end

    always_comb begin
        a_r4_windows_disjoint: assert ($onehot0({hit.shared_sel, hit.reg_win, hit.ram_win, hit.rom_win}));
    end

endmodule

// File: rtl/xbd_seq.sv
module xbd_seq
    import xbd_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              phase,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rw,
    input  logic [DATA_W-1:0] din,
    output logic [ADDR_W-1:0] addr_q,
    output logic              rw_q,
    output logic [DATA_W-1:0] din_q,
    output logic              access,
    output logic              commit
);
    bus_state_t state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (phase)  state_nx = ST_HIGH;
            ST_HIGH:   if (!phase) state_nx = ST_COMMIT;
            ST_COMMIT: state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        access = 1'b0;
        commit = 1'b0;
        unique case (state)
            ST_IDLE:   ;
            ST_HIGH:   access = 1'b1;
            ST_COMMIT: commit = 1'b1;
            default:   ;
        endcase
    end

    // Address and direction frozen at the phase rise; data tracked while high.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            rw_q   <= 1'b1;
            din_q  <= '0;
        end else begin
            if (state == ST_IDLE && phase) begin
                addr_q <= addr;
                rw_q   <= rw;
            end
            if (phase && state != ST_COMMIT) din_q <= din;
        end
    end

    a_r9_addr_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HIGH && $past(state == ST_HIGH)) |-> ($stable(addr_q) && $stable(rw_q)));

    a_r10_commit_after_high: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_COMMIT) |-> $past(state == ST_HIGH));

endmodule

// File: rtl/xbd_regs.sv
module xbd_regs
    import xbd_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int NFUNC   = 4,
    parameter int SEL_BIT = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit,
    input  logic              rw_q,
    input  hit_t              hit,
    input  logic [DATA_W-1:0] din_q,
    input  logic [NFUNC-1:0]  irq_req,
    output logic              sel,
    output logic [DATA_W-1:0] led,
    output logic [NFUNC-1:0]  ien,
    output logic [DATA_W-1:0] status
);
    logic wr;
    assign wr = commit && !rw_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel <= 1'b0;
            led <= '0;
            ien <= '0;
        end else if (wr) begin
            if (hit.shared_sel)      sel <= din_q[SEL_BIT];
            if (sel && hit.led_reg)  led <= din_q;
            if (sel && hit.ien_reg)  ien <= din_q[NFUNC-1:0];
        end
    end

    genvar i;
    generate
        for (i = 0; i < DATA_W; i++) begin : g_status
            if (i < NFUNC) begin : g_own
                assign status[i] = irq_req[i] & ien[i];
            end else begin : g_free
                assign status[i] = 1'b0;
            end
        end
    endgenerate

    a_r2_select_load: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && hit.shared_sel) |=> (sel == $past(din_q[SEL_BIT])));

    a_r3_led_locked: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |=> ($stable(led) && $stable(ien)));

endmodule

// File: rtl/xbus_dev_decoder.sv
module xbus_dev_decoder
    import xbd_pkg::*;
#(
    parameter int NFUNC     = 4,
    parameter int SEL_BIT   = 0,
    parameter int REG_BASE  = 16'hD100,
    parameter int REG_BYTES = 256,
    parameter int RAM_BASE  = 16'hD600,
    parameter int RAM_BYTES = 512,
    parameter int ROM_BASE  = 16'hD800,
    parameter int ROM_BYTES = 2048
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        phase,
    input  logic [15:0] addr,
    input  logic        rw,
    input  logic [7:0]  din,
    input  logic [7:0]  mem_rdata,
    input  logic [3:0]  irq_req,
    output logic [7:0]  dout,
    output logic [7:0]  doe,
    output logic        cs_reg,
    output logic        cs_ram,
    output logic        cs_rom,
    output logic [7:0]  led
);
    localparam int          ADDR_W   = 16;
    localparam int          DATA_W   = 8;
    localparam logic [7:0]  OWN_MASK = 8'((1 << NFUNC) - 1);

    logic [ADDR_W-1:0] addr_q;
    logic              rw_q;
    logic [DATA_W-1:0] din_q;
    logic              access, commit;
    hit_t              hit;
    logic              sel;
    logic [NFUNC-1:0]  ien;
    logic [DATA_W-1:0] status;
    logic              any_win;

    xbd_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .phase(phase), .addr(addr), .rw(rw), .din(din),
        .addr_q(addr_q), .rw_q(rw_q), .din_q(din_q), .access(access), .commit(commit)
    );

    xbd_decode #(
        .REG_BASE(REG_BASE), .REG_BYTES(REG_BYTES), .RAM_BASE(RAM_BASE),
        .RAM_BYTES(RAM_BYTES), .ROM_BASE(ROM_BASE), .ROM_BYTES(ROM_BYTES)
    ) u_dec (
        .addr(addr_q), .hit(hit)
    );

    xbd_regs #(.DATA_W(DATA_W), .NFUNC(NFUNC), .SEL_BIT(SEL_BIT)) u_regs (
        .clk(clk), .rst_n(rst_n), .commit(commit), .rw_q(rw_q), .hit(hit),
        .din_q(din_q), .irq_req(irq_req), .sel(sel), .led(led), .ien(ien), .status(status)
    );

    always_comb begin
        any_win = sel && (hit.reg_win || hit.ram_win || hit.rom_win);
        cs_reg  = access && sel && hit.reg_win;
        cs_ram  = access && sel && hit.ram_win;
        cs_rom  = access && sel && hit.rom_win;
        dout    = '0;
        doe     = '0;
        if (access && rw_q) begin
            if (hit.shared_sel) begin
                doe  = OWN_MASK;
                dout = status & OWN_MASK;
            end else if (any_win) begin
                doe = '1;
                if (hit.led_reg)      dout = led;
                else if (hit.ien_reg) dout = DATA_W'(ien);
                else                  dout = mem_rdata;
            end
        end
    end

    a_r6_owned_bits_only: assert property (@(posedge clk) disable iff (!rst_n)
        (access && hit.shared_sel) |-> ((doe & ~OWN_MASK) == 8'h00));

    a_r4_single_select: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cs_reg, cs_ram, cs_rom}));

    a_r7_drive_in_phase: assert property (@(posedge clk) disable iff (!rst_n)
        (doe != 8'h00) |-> ($past(phase) && rw_q));

    a_r3_off_bus: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |-> !(cs_reg || cs_ram || cs_rom));

endmodule

// File: tb/xbus_dev_decoder_test.sv
module xbus_dev_decoder_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        phase = 1'b0;
    logic [15:0] addr = 16'h0000;
    logic        rw = 1'b1;
    logic [7:0]  din = 8'h00;
    logic [7:0]  mem_rdata = 8'h00;
    logic [3:0]  irq_req = 4'h0;
    logic [7:0]  dout, doe, led;
    logic        cs_reg, cs_ram, cs_rom;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // bench model
    bit         m_sel = 1'b0;
    logic [7:0] m_led = 8'h00;
    logic [3:0] m_ien = 4'h0;

    always #(CLK_PERIOD/2) clk = ~clk;

    xbus_dev_decoder uut (
        .clk(clk), .rst_n(rst_n), .phase(phase), .addr(addr), .rw(rw), .din(din),
        .mem_rdata(mem_rdata), .irq_req(irq_req), .dout(dout), .doe(doe),
        .cs_reg(cs_reg), .cs_ram(cs_ram), .cs_rom(cs_rom), .led(led)
    );

    function automatic logic [2:0] exp_cs(input logic [15:0] a);
        if (!m_sel) return 3'b000;
        if (a >= 16'hD100 && a <= 16'hD1FE) return 3'b100;
        if (a >= 16'hD600 && a <= 16'hD7FF) return 3'b010;
        if (a >= 16'hD800 && a <= 16'hDFFF) return 3'b001;
        return 3'b000;
    endfunction

    function automatic logic [7:0] exp_doe(input logic [15:0] a, input logic r);
        if (!r) return 8'h00;
        if (a == 16'hD1FF) return 8'h0F;
        if (exp_cs(a) != 3'b000) return 8'hFF;
        return 8'h00;
    endfunction

    function automatic logic [7:0] exp_dout(input logic [15:0] a);
        if (a == 16'hD1FF) return {4'h0, irq_req & m_ien};
        if (a == 16'hD100) return m_led;
        if (a == 16'hD101) return {4'h0, m_ien};
        return mem_rdata;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_high(input string req, input logic [15:0] a, input logic r);
        logic [7:0] e;
        e = exp_doe(a, r);
        check({req, " cs"}, {29'd0, cs_reg, cs_ram, cs_rom}, {29'd0, exp_cs(a)});
        check({req, " doe"}, {24'd0, doe}, {24'd0, e});
        if (e != 8'h00) check({req, " dout"}, {24'd0, dout & e}, {24'd0, exp_dout(a) & e});
    endtask

    // one bus cycle; glitch swaps address and direction mid-phase (R9)
    task automatic bus_cycle(input logic [15:0] a, input logic r, input logic [7:0] d,
                             input bit glitch, input string req);
        @(negedge clk);
        addr = a; rw = r; din = d; phase = 1'b0;
        repeat (2) @(negedge clk);
        phase = 1'b1;
        @(negedge clk);
        check_high(req, a, r);
        if (glitch) begin
            addr = a ^ 16'h0E37;
            rw   = ~r;
            @(negedge clk);
            check_high({req, " R9 after glitch"}, a, r);
        end
        @(negedge clk);
        phase = 1'b0;
        repeat (3) @(negedge clk);
        if (!r) begin
            if (a == 16'hD1FF) m_sel = d[0];
            else if (m_sel && a == 16'hD100) m_led = d;
            else if (m_sel && a == 16'hD101) m_ien = d[3:0];
        end
        check({req, " led"}, {24'd0, led}, {24'd0, m_led});
        check({req, " idle"}, {21'd0, cs_reg, cs_ram, cs_rom, doe}, 32'd0);
    endtask

    function automatic logic [15:0] pick_addr();
        unique case ($urandom % 9)
            0: return 16'hD100;
            1: return 16'hD101;
            2: return 16'hD1FF;
            3: return 16'hD100 + 16'($urandom % 255);
            4: return 16'hD600 + 16'($urandom % 512);
            5: return 16'hD800 + 16'($urandom % 2048);
            6: return 16'hD200 + 16'($urandom % 1024);
            7: return 16'hE000 + 16'($urandom % 8192);
            default: return 16'($urandom);
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        repeat (3) @(negedge clk);
        check("R1 reset outputs", {led, doe, 5'd0, cs_reg, cs_ram, cs_rom}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        mem_rdata = 8'h3C;
        // R3: deselected device ignores windows and register writes
        bus_cycle(16'hD600, 1'b1, 8'h00, 1'b0, "R3 ram read while off");
        bus_cycle(16'hD100, 1'b0, 8'h55, 1'b0, "R3 led write while off");
        // R6: shared byte readable while deselected; enables still zero (R1)
        irq_req = 4'hF;
        bus_cycle(16'hD1FF, 1'b1, 8'h00, 1'b0, "R6 R1 status off");
        // R2: stray bits only, select bit clear
        bus_cycle(16'hD1FF, 1'b0, 8'hFE, 1'b0, "R2 stray bits");
        bus_cycle(16'hD800, 1'b1, 8'h00, 1'b0, "R2 still off");
        bus_cycle(16'hD1FF, 1'b0, 8'h01, 1'b0, "R2 select");
        bus_cycle(16'hD100, 1'b1, 8'h00, 1'b0, "R3 R8 led unchanged");
        bus_cycle(16'hD100, 1'b0, 8'hA5, 1'b0, "R5 led write");
        bus_cycle(16'hD101, 1'b0, 8'hF5, 1'b0, "R5 enable write");
        bus_cycle(16'hD101, 1'b1, 8'h00, 1'b0, "R8 enable read");
        irq_req = 4'b0111;
        bus_cycle(16'hD1FF, 1'b1, 8'h00, 1'b0, "R6 masked status");
        bus_cycle(16'hD1FE, 1'b1, 8'h00, 1'b0, "R4 reg top");
        bus_cycle(16'hD5FF, 1'b1, 8'h00, 1'b0, "R4 gap");
        bus_cycle(16'hD7FF, 1'b1, 8'h00, 1'b0, "R4 ram top");
        bus_cycle(16'hDFFF, 1'b1, 8'h00, 1'b0, "R4 rom top");
        bus_cycle(16'hE000, 1'b1, 8'h00, 1'b0, "R4 past rom");
        bus_cycle(16'hD600, 1'b0, 8'h11, 1'b0, "R7 write no drive");
        bus_cycle(16'hD100, 1'b0, 8'h5A, 1'b1, "R9 R10 glitched write");
        bus_cycle(16'hD800, 1'b1, 8'h00, 1'b1, "R9 glitched read");

        for (int n = 0; n < 600; n++) begin
            logic [15:0] a;
            logic [7:0]  d;
            a = pick_addr();
            d = 8'($urandom);
            irq_req   = 4'($urandom);
            mem_rdata = 8'($urandom);
            bus_cycle(a, 1'($urandom), d, ($urandom % 4) == 0, "R4 R6 R7 R8 random");
        end

        bus_cycle(16'hD1FF, 1'b0, 8'hFE, 1'b0, "R2 deselect");
        bus_cycle(16'hD7FF, 1'b1, 8'h00, 1'b0, "R3 off again");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule